// File: doc/BRIEF.md
# Processor Status Register and Interrupt Entry Selector

This block keeps the 8-bit processor status word of a small 8-bit core and decides which entry event the core services next: a reset, a non-maskable interrupt, a software break, or a maskable interrupt request. The ALU, flag set and clear instructions, and status pulls from the stack all write the register. The block shows the current status value and the byte the core must push for the event on offer. It also gives the 16-bit address from which the core fetches the entry vector. The surrounding sequencer pushes the bytes and fetches the vector.

Entry events leave the block on a valid/ready handshake. `svc_valid` offers an event, and `svc_kind`, `vec_addr` and `push_byte` describe it. The sequencer accepts the event by raising `svc_ready` in a cycle where `svc_valid` is high. Back-pressure works as follows. The sequencer may hold `svc_ready` low for any number of cycles. Once an event has been offered and not accepted, that event stays on offer and keeps its kind and vector until it is accepted, even if an event of higher priority arrives or the request that raised it goes away. The push byte follows the live status value. The event is consumed at the clock edge where both signals are high.

The status value presents bits 7 down to 0 as N, V, a fixed 1, B, D, I, Z, C. The B position reads 0 in the register. It is 1 only in the push byte of a break entry.

Top module: `psr_irq_ctrl`

## Requirements
- R1: `p_out` bit 5 always reads 1 and bit 4 always reads 0. After reset `p_out` is 8'h24, with only I (bit 2) and bit 5 set.
- R2: Each bit of `alu_we` loads one flag at the next edge: bit 0 loads C from `alu_carry`, bit 1 loads Z with 1 when `alu_res` is zero, bit 2 loads V from `alu_ovf`, and bit 3 loads N from `alu_res[7]`. Flags with a 0 enable keep their value.
- R3: When `cmd_valid` is high, the flag picked by `cmd_flag` (0 = C, 1 = I, 2 = D, 3 = V) takes the value of `cmd_value` at the next edge.
- R4: When `pull_en` is high, N, V, D, I, Z and C load bits 7, 6, 3, 2, 1 and 0 of `pull_data`. Bits 5 and 4 of `pull_data` have no effect.
- R5: After reset a reset entry is on offer with `svc_kind` = 0 and `vec_addr` = 16'hFFFC. It is offered only once and is gone after acceptance.
- R6: A rising edge on `nmi_in` is latched and later offered with `svc_kind` = 1 and `vec_addr` = 16'hFFFA, whatever the state of I. Each rising edge gives exactly one entry, and a level held high gives no second one.
- R7: A high `irq_in` with I = 0 is offered in the same cycle with `svc_kind` = 3 and `vec_addr` = 16'hFFFE. With I = 1 it is ignored. Its push byte has bit 4 = 0.
- R8: A `brk_req` pulse is latched and offered with `svc_kind` = 2 and `vec_addr` = 16'hFFFE, whatever the state of I. Its push byte is `p_out` with bit 4 set.
- R9: When several events are pending and none is held on offer, the order is reset, then NMI, then break, then IRQ.
- R10: Acceptance (`svc_valid` and `svc_ready` both high) sets I at that edge. An offer that is not accepted keeps its `svc_kind` until it is accepted.
- R11: When several writes hit in the same cycle, a pull overrides commands and ALU updates, a command overrides the ALU for its own flag, and acceptance forces I to 1 over everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_we | input | 4 | Per-flag ALU update enables (C, Z, V, N from bit 0 up) |
| alu_res | input | 8 | ALU result byte for N and Z |
| alu_carry | input | 1 | ALU unsigned carry |
| alu_ovf | input | 1 | ALU signed overflow |
| cmd_valid | input | 1 | Explicit flag write strobe |
| cmd_flag | input | 2 | Flag chosen by the command |
| cmd_value | input | 1 | Value written by the command |
| pull_en | input | 1 | Load status from a stack pull |
| pull_data | input | 8 | Byte pulled from the stack |
| nmi_in | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| irq_in | input | 1 | Maskable interrupt request, level sensitive |
| brk_req | input | 1 | One-cycle software break request |
| svc_valid | output | 1 | An entry event is on offer |
| svc_ready | input | 1 | Sequencer accepts the offered event |
| svc_kind | output | 2 | Offered event: 0 reset, 1 NMI, 2 break, 3 IRQ |
| vec_addr | output | 16 | Vector address of the offered event |
| push_byte | output | 8 | Status byte to push for the offered event |
| p_out | output | 8 | Current status value |

## Verification
A wrong flag in the register is visible on `p_out` one edge after the write that caused it. A wrong pending latch or a wrong held offer changes `svc_valid` or `svc_kind` in the first cycle it exists. This is often earlier than the event that should have been served, because IRQ masking and priority are decided combinationally from that state. A lost acceptance shows up as I staying clear or as the same event being offered a second time right after it was consumed. The stimulus mixes back-pressure with events that arrive while an offer is held, so these faults appear within a few cycles.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int P_W = 8;
  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_B = 4;
  localparam int B_U = 5;
  localparam int B_V = 6;
  localparam int B_N = 7;
  localparam int WE_C = 0;
  localparam int WE_Z = 1;
  localparam int WE_V = 2;
  localparam int WE_N = 3;
  localparam int WE_W = 4;
  localparam logic [P_W-1:0] P_RESET = 8'h24;

  typedef enum logic [1:0] {
    SVC_RST = 2'd0,
    SVC_NMI = 2'd1,
    SVC_BRK = 2'd2,
    SVC_IRQ = 2'd3
  } svc_kind_t;

  typedef enum logic [1:0] {
    CF_C = 2'd0,
    CF_I = 2'd1,
    CF_D = 2'd2,
    CF_V = 2'd3
  } cmd_flag_t;
endpackage

// File: rtl/psr_flag_reg.sv
module psr_flag_reg
  import psr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WE_W-1:0] alu_we,
  input  logic [P_W-1:0]  alu_res,
  input  logic            alu_carry,
  input  logic            alu_ovf,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_flag,
  input  logic            cmd_value,
  input  logic            pull_en,
  input  logic [P_W-1:0]  pull_data,
  input  logic            force_i,
  output logic [P_W-1:0]  p_q
);
  logic [P_W-1:0] p_nx;

  always_comb begin
    p_nx = p_q;
    // lowest precedence: ALU flag updates
    if (alu_we[WE_C]) p_nx[B_C] = alu_carry;
    if (alu_we[WE_Z]) p_nx[B_Z] = (alu_res == '0);
    if (alu_we[WE_V]) p_nx[B_V] = alu_ovf;
    if (alu_we[WE_N]) p_nx[B_N] = alu_res[P_W-1];
    // explicit commands win over the ALU for their own flag
    if (cmd_valid) begin
      case (cmd_flag_t'(cmd_flag))
        CF_C:    p_nx[B_C] = cmd_value;
        CF_I:    p_nx[B_I] = cmd_value;
        CF_D:    p_nx[B_D] = cmd_value;
        default: p_nx[B_V] = cmd_value;
      endcase
    end
    // a stack pull replaces the whole word
    if (pull_en) p_nx = pull_data;
    // entry acceptance masks further IRQs
    if (force_i) p_nx[B_I] = 1'b1;
    // fixed positions
    p_nx[B_U] = 1'b1;
    p_nx[B_B] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= P_RESET;
    else        p_q <= p_nx;
  end
endmodule

// File: rtl/psr_evt_latch.sv
module psr_evt_latch #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic pend
);
  logic set_now;

  generate
    if (EDGE) begin : g_edge
      logic evt_d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_d <= 1'b0;
        else        evt_d <= evt;
      end
      assign set_now = evt & ~evt_d;
    end else begin : g_pulse
      assign set_now = evt;
    end
  endgenerate

  // a new event in the clearing cycle stays pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_now) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end
endmodule

// File: rtl/psr_svc_arb.sv
module psr_svc_arb
  import psr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      nmi_pend,
  input  logic      brk_pend,
  input  logic      irq_in,
  input  logic      i_flag,
  input  logic      svc_ready,
  output logic      svc_valid,
  output svc_kind_t svc_kind,
  output logic      accept
);
  logic      rst_pend;
  logic      held_q;
  svc_kind_t held_kind_q;
  logic      live_valid;
  svc_kind_t live_kind;

  always_comb begin
    live_valid = 1'b1;
    live_kind  = SVC_RST;
    if (rst_pend)                live_kind = SVC_RST;
    else if (nmi_pend)           live_kind = SVC_NMI;
    else if (brk_pend)           live_kind = SVC_BRK;
    else if (irq_in && !i_flag)  live_kind = SVC_IRQ;
    else                         live_valid = 1'b0;
  end

  assign svc_valid = held_q | live_valid;
  assign svc_kind  = held_q ? held_kind_q : live_kind;
  assign accept    = svc_valid & svc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend    <= 1'b1;
      held_q      <= 1'b0;
      held_kind_q <= SVC_RST;
    end else begin
      if (accept && svc_kind == SVC_RST) rst_pend <= 1'b0;
      if (accept) begin
        held_q <= 1'b0;
      end else if (svc_valid) begin
        held_q      <= 1'b1;
        held_kind_q <= svc_kind;
      end
    end
  end
endmodule

// File: rtl/psr_irq_ctrl.sv
module psr_irq_ctrl
  import psr_pkg::*;
#(
  parameter int                 VEC_W   = 16,
  parameter logic [VEC_W-1:0]   VEC_NMI = 16'hFFFA,
  parameter logic [VEC_W-1:0]   VEC_RST = 16'hFFFC,
  parameter logic [VEC_W-1:0]   VEC_IRQ = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       alu_we,
  input  logic [7:0]       alu_res,
  input  logic             alu_carry,
  input  logic             alu_ovf,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_flag,
  input  logic             cmd_value,
  input  logic             pull_en,
  input  logic [7:0]       pull_data,
  input  logic             nmi_in,
  input  logic             irq_in,
  input  logic             brk_req,
  output logic             svc_valid,
  input  logic             svc_ready,
  output logic [1:0]       svc_kind,
  output logic [VEC_W-1:0] vec_addr,
  output logic [7:0]       push_byte,
  output logic [7:0]       p_out
);
  logic      accept;
  svc_kind_t kind;
  logic      nmi_pend;
  logic      brk_pend;
  logic [P_W-1:0] p_q;

  psr_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_we    (alu_we),
    .alu_res   (alu_res),
    .alu_carry (alu_carry),
    .alu_ovf   (alu_ovf),
    .cmd_valid (cmd_valid),
    .cmd_flag  (cmd_flag),
    .cmd_value (cmd_value),
    .pull_en   (pull_en),
    .pull_data (pull_data),
    .force_i   (accept),
    .p_q       (p_q)
  );

  psr_evt_latch #(.EDGE(1'b1)) u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (nmi_in),
    .clr   (accept && kind == SVC_NMI),
    .pend  (nmi_pend)
  );

  psr_evt_latch #(.EDGE(1'b0)) u_brk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (brk_req),
    .clr   (accept && kind == SVC_BRK),
    .pend  (brk_pend)
  );

  psr_svc_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_pend  (nmi_pend),
    .brk_pend  (brk_pend),
    .irq_in    (irq_in),
    .i_flag    (p_q[B_I]),
    .svc_ready (svc_ready),
    .svc_valid (svc_valid),
    .svc_kind  (kind),
    .accept    (accept)
  );

  always_comb begin
    case (kind)
      SVC_RST: vec_addr = VEC_RST;
      SVC_NMI: vec_addr = VEC_NMI;
      default: vec_addr = VEC_IRQ;
    endcase
  end

  always_comb begin
    push_byte       = p_q;
    push_byte[B_B]  = (kind == SVC_BRK);
  end

  assign svc_kind = kind;
  assign p_out    = p_q;
endmodule

// File: rtl/psr_irq_ctrl_chk.sv
module psr_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we_n,
  input logic        we_z,
  input logic [7:0]  alu_res,
  input logic        pull_en,
  input logic [7:0]  pull_data,
  input logic        svc_valid,
  input logic        svc_ready,
  input logic [1:0]  svc_kind,
  input logic [15:0] vec_addr,
  input logic [7:0]  push_byte,
  input logic [7:0]  p_out
);
  logic acc;
  assign acc = svc_valid & svc_ready;

  p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    p_out[5] && !p_out[4]);

  p_alu_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && !pull_en) |=> p_out[7] == $past(alu_res[7]));

  p_alu_z_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_z && !pull_en) |=> p_out[1] == ($past(alu_res) == 8'h00));

  p_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en && !acc) |=> p_out == (($past(pull_data) & 8'hCF) | 8'h20));

  p_rst_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_kind == 2'd0) |-> vec_addr == 16'hFFFC);

  p_nmi_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_kind == 2'd1) |-> vec_addr == 16'hFFFA);

  p_irq_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_valid) && svc_kind == 2'd3) |-> !p_out[2]);

  p_brk_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> push_byte[4] == (svc_kind == 2'd2));

  p_accept_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> p_out[2]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && !svc_ready) |=> (svc_valid && $stable(svc_kind)));
endmodule

bind psr_irq_ctrl psr_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .we_n      (alu_we[3]),
  .we_z      (alu_we[1]),
  .alu_res   (alu_res),
  .pull_en   (pull_en),
  .pull_data (pull_data),
  .svc_valid (svc_valid),
  .svc_ready (svc_ready),
  .svc_kind  (svc_kind),
  .vec_addr  (vec_addr),
  .push_byte (push_byte),
  .p_out     (p_out)
);

// File: tb/psr_irq_ctrl_tb.sv
module psr_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alu_we = '0;
  logic [7:0]  alu_res = '0;
  logic        alu_carry = 1'b0, alu_ovf = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_flag = '0;
  logic        cmd_value = 1'b0;
  logic        pull_en = 1'b0;
  logic [7:0]  pull_data = '0;
  logic        nmi_in = 1'b0, irq_in = 1'b0, brk_req = 1'b0;
  logic        svc_valid, svc_ready = 1'b0;
  logic [1:0]  svc_kind;
  logic [15:0] vec_addr;
  logic [7:0]  push_byte, p_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psr_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_res(alu_res),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .cmd_valid(cmd_valid),
    .cmd_flag(cmd_flag), .cmd_value(cmd_value), .pull_en(pull_en),
    .pull_data(pull_data), .nmi_in(nmi_in), .irq_in(irq_in),
    .brk_req(brk_req), .svc_valid(svc_valid), .svc_ready(svc_ready),
    .svc_kind(svc_kind), .vec_addr(vec_addr), .push_byte(push_byte),
    .p_out(p_out)
  );

  // reference model state
  logic [7:0] m_p;
  logic m_rst, m_nmi, m_brk, m_held, m_nprev;
  logic [1:0] m_hk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] vec_of(input logic [1:0] k);
    case (k)
      2'd0:    return 16'hFFFC;
      2'd1:    return 16'hFFFA;
      default: return 16'hFFFE;
    endcase
  endfunction

  task automatic model_reset();
    m_p = 8'h24; m_rst = 1; m_nmi = 0; m_brk = 0; m_held = 0; m_nprev = 0; m_hk = 0;
  endtask

  task automatic model_offer(output logic v, output logic [1:0] k);
    v = 1; k = 0;
    if (m_held)                  k = m_hk;
    else if (m_rst)              k = 0;
    else if (m_nmi)              k = 1;
    else if (m_brk)              k = 2;
    else if (irq_in && !m_p[2])  k = 3;
    else                         v = 0;
  endtask

  // checks outputs of this cycle, then advances the model over the edge
  task automatic tick();
    logic v, acc;
    logic [1:0] k;
    logic [7:0] np, eb;
    #1;
    model_offer(v, k);
    chk("R11 p_out", {8'h0, p_out}, {8'h0, m_p});
    chk("R9 svc_valid", {15'h0, svc_valid}, {15'h0, v});
    if (v) begin
      chk("R9 svc_kind", {14'h0, svc_kind}, {14'h0, k});
      case (k)
        2'd0: chk("R5 vec", vec_addr, vec_of(k));
        2'd1: chk("R6 vec", vec_addr, vec_of(k));
        2'd2: chk("R8 vec", vec_addr, vec_of(k));
        default: chk("R7 vec", vec_addr, vec_of(k));
      endcase
      eb = m_p; eb[4] = (k == 2'd2);
      chk(k == 2'd2 ? "R8 push" : "R1 push", {8'h0, push_byte}, {8'h0, eb});
    end
    acc = v & svc_ready;
    np = m_p;
    if (alu_we[0]) np[0] = alu_carry;
    if (alu_we[1]) np[1] = (alu_res == 8'h00);
    if (alu_we[2]) np[6] = alu_ovf;
    if (alu_we[3]) np[7] = alu_res[7];
    if (cmd_valid) begin
      case (cmd_flag)
        2'd0: np[0] = cmd_value;
        2'd1: np[2] = cmd_value;
        2'd2: np[3] = cmd_value;
        default: np[6] = cmd_value;
      endcase
    end
    if (pull_en) np = (pull_data & 8'hCF) | 8'h20;
    if (acc) np[2] = 1'b1;
    m_p = np;
    if (acc && k == 2'd0) m_rst = 0;
    m_nmi = (nmi_in && !m_nprev) | (m_nmi && !(acc && k == 2'd1));
    m_brk = brk_req | (m_brk && !(acc && k == 2'd2));
    if (acc) m_held = 0;
    else if (v) begin m_held = 1; m_hk = k; end
    m_nprev = nmi_in;
    @(posedge clk);
    @(negedge clk);
    alu_we = '0; cmd_valid = 0; pull_en = 0; brk_req = 0; svc_ready = 0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17C0DE));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 / R5: reset state and reset offer
    chk("R1 reset p_out", {8'h0, p_out}, 16'h0024);
    chk("R5 reset valid", {15'h0, svc_valid}, 16'h1);
    chk("R5 reset vec", vec_addr, 16'hFFFC);
    svc_ready = 1; tick();
    chk("R5 offered once", {15'h0, svc_valid}, 16'h0);

    // R2: ALU flag loads
    alu_we = 4'hF; alu_res = 8'h80; alu_carry = 1; alu_ovf = 1; tick();
    chk("R2 nvc", {8'h0, p_out}, 16'h00E5);
    alu_we = 4'b0010; alu_res = 8'h00; alu_carry = 0; alu_ovf = 0; tick();
    chk("R2 z only", {8'h0, p_out}, 16'h00E7);

    // R3: commands
    cmd_valid = 1; cmd_flag = 2'd1; cmd_value = 0; tick();
    chk("R3 clear I", {8'h0, p_out}, 16'h00E3);
    cmd_valid = 1; cmd_flag = 2'd0; cmd_value = 0; tick();
    chk("R3 clear C", {8'h0, p_out}, 16'h00E2);

    // R4: pulls ignore bits 5 and 4
    pull_en = 1; pull_data = 8'hFF; tick();
    chk("R4 pull ff", {8'h0, p_out}, 16'h00EF);
    pull_en = 1; pull_data = 8'h00; tick();
    chk("R4 pull 00", {8'h0, p_out}, 16'h0020);

    // R11: pull wins over command and ALU in the same cycle
    pull_en = 1; pull_data = 8'h01; alu_we = 4'hF; alu_res = 8'h80;
    cmd_valid = 1; cmd_flag = 2'd3; cmd_value = 1; tick();
    chk("R11 precedence", {8'h0, p_out}, 16'h0021);

    // R7 / R10: IRQ offered, held under back-pressure while NMI arrives
    irq_in = 1; #1;
    chk("R7 irq valid", {15'h0, svc_valid}, 16'h1);
    chk("R7 irq push B", {15'h0, push_byte[4]}, 16'h0);
    tick();
    nmi_in = 1; tick();
    chk("R10 held kind", {14'h0, svc_kind}, 16'h3);
    svc_ready = 1; tick();
    chk("R10 accept sets I", {15'h0, p_out[2]}, 16'h1);
    chk("R6 nmi kind", {14'h0, svc_kind}, 16'h1);
    chk("R6 nmi vec", vec_addr, 16'hFFFA);
    svc_ready = 1; tick();
    chk("R7 masked", {15'h0, svc_valid}, 16'h0);
    tick();
    chk("R6 one per edge", {15'h0, svc_valid}, 16'h0);
    nmi_in = 0; irq_in = 0; tick();

    // R9 / R8: NMI and break together, with I set
    nmi_in = 1; brk_req = 1; tick();
    chk("R9 nmi first", {14'h0, svc_kind}, 16'h1);
    svc_ready = 1; tick();
    chk("R8 brk kind", {14'h0, svc_kind}, 16'h2);
    chk("R8 brk push B", {15'h0, push_byte[4]}, 16'h1);
    svc_ready = 1; tick();
    chk("R8 brk consumed", {15'h0, svc_valid}, 16'h0);
    nmi_in = 0; tick();

    // constrained random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(1, 0) == 1) alu_we = 4'($urandom());
      alu_res   = ($urandom_range(3, 0) == 0) ? 8'h00 : 8'($urandom());
      alu_carry = 1'($urandom());
      alu_ovf   = 1'($urandom());
      cmd_valid = ($urandom_range(7, 0) == 0);
      cmd_flag  = 2'($urandom());
      cmd_value = 1'($urandom());
      pull_en   = ($urandom_range(15, 0) == 0);
      pull_data = 8'($urandom());
      brk_req   = ($urandom_range(31, 0) == 0);
      if ($urandom_range(15, 0) == 0) nmi_in = ~nmi_in;
      if ($urandom_range(7, 0) == 0)  irq_in = ~irq_in;
      svc_ready = 1'($urandom());
      tick();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule